// File: doc/BRIEF.md
# Strap-Configured Host Port Decoder

This block sits at the host-facing edge of a display controller. It decides, on every cycle, whether the host bus is addressing the controller's bank of sixteen internal registers or its display-memory window. The decision uses a 16-bit strap word. That word is taken from pins that are pulled high or low on the board, and it is captured when reset is released. The straps set the host bus width, the bus protocol, the register addressing style and byte swapping. They also give the I/O base address and the memory window base.

Registers can be reached in two ways. In direct mode, each register sits at its own even I/O address. In indexed mode, two adjacent addresses are used: the base address selects a 4-bit index register, and base+1 is a data port that reaches the register the index names. The decode outputs are combinational from the captured straps and the current address and strobes. The only clocked state is the strap word and the index register.

Top module: `host_port_decoder`

## Requirements
- R1: While `rst_n` is low, the strap word follows `strap_i` on every clock. From the first clock with `rst_n` high it is held, and later changes on `strap_i` have no effect on the `cfg_*` outputs or on decoding until the next reset.
- R2: Strap bit 0 = 0 selects an 8-bit host bus. Index writes then take the index from `hdata_i[3:0]`, `hdata_i[15:8]` is ignored, and read-back data has its upper byte at zero. Strap bit 0 = 1 selects a 16-bit bus.
- R3: Strap bit 1 = 1 selects direct mapping. Host address bits 9..5 are compared with strap bits 12..8, `reg_sel_o` equals address bits 4..1, any address bit 0 gives `reg_hit_o`, and `idx_hit_o` stays low.
- R4: Strap bit 1 = 0 selects indexed mapping. Address bits 9..1 are compared with strap bits 12..4. A hit with address bit 0 = 0 raises `idx_hit_o`, and a hit with address bit 0 = 1 raises `reg_hit_o`. In this mode `reg_sel_o` equals the index register.
- R5: Strap bit 2 = 1 selects a 68000-style protocol. `io_rd_n` acts as the address strobe and `io_wr_n` as read/not-write (low means write). Strap bit 2 = 0 selects separate active-low read and write strobes.
- R6: Strap bit 3 = 1 together with a 16-bit bus swaps the bytes. Index writes use `hdata_i[11:8]` and read-back places the index in bits 11..8. With an 8-bit bus this bit has no effect.
- R7: `io_hit_o` is high exactly when `io_cs_n` is low, an I/O strobe is active, and the address compare of R3 or R4 matches. Address bits 19..10 do not take part.
- R8: `mem_hit_o` is high exactly when `mem_cs_n` is low and address bits 19..17 equal strap bits 15..13.
- R9: The index register is 4 bits wide and is zero after reset. An index write during an active write strobe loads it on the next clock. An index-port read drives it on `rd_data_o`; every other cycle drives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strap_i | input | 16 | Strap word from the memory data pins |
| haddr_i | input | 20 | Host address |
| hdata_i | input | 16 | Host write data |
| io_cs_n | input | 1 | I/O chip select, active low |
| io_rd_n | input | 1 | I/O read strobe, or address strobe in 68000 mode |
| io_wr_n | input | 1 | I/O write strobe, or read/not-write in 68000 mode |
| mem_cs_n | input | 1 | Memory chip select, active low |
| io_hit_o | output | 1 | Valid I/O cycle to this block |
| mem_hit_o | output | 1 | Valid display-memory cycle |
| idx_hit_o | output | 1 | Index register addressed |
| reg_hit_o | output | 1 | Internal register (or data port) addressed |
| reg_sel_o | output | 4 | Selected internal register number |
| rd_data_o | output | 16 | Index read-back data |
| cfg_bus16_o | output | 1 | Captured bus-width strap |
| cfg_direct_o | output | 1 | Captured mapping-style strap |
| cfg_m68k_o | output | 1 | Captured protocol strap |
| cfg_swap_o | output | 1 | Captured byte-swap strap |

## Verification
The bench repeats reset with six strap words. After each reset it drives the inverse strap word, so a latch that keeps tracking its pins would change mode and base in the middle of a run. Addresses flip one compared bit at a time. This catches a compare that is off by one bit, that includes the direct-mode register bits, or that looks at address bit 0 or the upper I/O bits. A wrong protocol decode would miss the 68000 address-strobe cycles or count a read as a write. A swap that ignores bus width would load the index from the wrong byte in 8-bit mode.

// File: rtl/hpd_pkg.sv
// Shared types for the host port decoder.
// Assumes the strap word layout below; the bit order is the wiring contract.
package hpd_pkg;
    localparam int STRAP_W  = 16;
    localparam int IO_BASE_W = 9;
    localparam int MEM_BASE_W = 3;
    localparam int IDX_W    = 4;

    typedef struct packed {
        logic [MEM_BASE_W-1:0] mem_base; // compared with address 19..17
        logic [IO_BASE_W-1:0]  io_base;  // compared with address 9..1
        logic                  swap;
        logic                  m68k;
        logic                  direct;
        logic                  bus16;
    } strap_t;
endpackage

// File: rtl/hpd_strap_latch.sv
// Captures the strap word while reset is held and freezes it afterwards.
// Assumes straps are stable for at least one clock before reset release.
module hpd_strap_latch
    import hpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    output strap_t             cfg_o
);
    strap_t cfg_q;

    // Track the pins during reset, hold from release on.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= strap_t'(strap_i);
    end

    assign cfg_o = cfg_q;

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));
endmodule

// File: rtl/hpd_strobe_decode.sv
// Turns the two I/O strobes into active/write/read flags for either protocol.
// Assumes strobes are active low in both protocols.
module hpd_strobe_decode (
    input  logic m68k_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic active_o,
    output logic write_o,
    output logic read_o
);
    // Protocol-dependent strobe interpretation.
    always_comb begin
        if (m68k_i) begin
            active_o = !rd_n_i;
            write_o  = !rd_n_i && !wr_n_i;
        end else begin
            active_o = !rd_n_i || !wr_n_i;
            write_o  = !wr_n_i;
        end
        read_o = active_o && !write_o;
    end
endmodule

// File: rtl/hpd_addr_match.sv
// Compares the host address with the strapped I/O and memory bases.
// Assumes direct mode leaves DIR_BITS low address bits for register select.
module hpd_addr_match
    import hpd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DIR_BITS = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strap_t            cfg_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic              io_cs_n,
    input  logic              mem_cs_n,
    input  logic              active_i,
    output logic              io_hit_o,
    output logic              mem_hit_o
);
    localparam int MEM_LO = ADDR_W - MEM_BASE_W;

    logic [IO_BASE_W-1:0] io_addr;
    logic [IO_BASE_W-1:0] cmp_mask;
    logic                 io_match;
    logic                 unused_addr;

    assign io_addr     = haddr_i[IO_BASE_W:1];
    assign unused_addr = &{1'b0, haddr_i[MEM_LO-1:IO_BASE_W+1], haddr_i[0]};

    // Mask out register-select bits in direct mode.
    always_comb begin
        for (int b = 0; b < IO_BASE_W; b++) begin
            cmp_mask[b] = !(cfg_i.direct && (b < DIR_BITS));
        end
    end

    // Base compares and chip-select qualification.
    always_comb begin
        io_match  = ((io_addr ^ cfg_i.io_base) & cmp_mask) == '0;
        io_hit_o  = !io_cs_n && active_i && io_match;
        mem_hit_o = !mem_cs_n && (haddr_i[ADDR_W-1:MEM_LO] == cfg_i.mem_base);
    end

    // R8
    mem_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit_o |-> (!mem_cs_n && haddr_i[ADDR_W-1:MEM_LO] == cfg_i.mem_base));
    // R7
    io_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit_o |-> (!io_cs_n && active_i));
endmodule

// File: rtl/hpd_index_reg.sv
// Four-bit register index, loaded by host writes to the index port.
// Assumes the write enable is already qualified by decode.
module hpd_index_reg
    import hpd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wdata_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_q;

    // Clear on reset, load on index write.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (we_i) idx_q <= wdata_i;
    end

    assign idx_o = idx_q;

    // R9
    idx_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_q) |-> $past(we_i));
endmodule

// File: rtl/host_port_decoder.sv
// Top of the host port decoder: strap capture, strobe and address decode,
// index register and byte-lane steering. Assumes straps settle during reset.
module host_port_decoder
    import hpd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [DATA_W-1:0] hdata_i,
    input  logic              io_cs_n,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    input  logic              mem_cs_n,
    output logic              io_hit_o,
    output logic              mem_hit_o,
    output logic              idx_hit_o,
    output logic              reg_hit_o,
    output logic [IDX_W-1:0]  reg_sel_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              cfg_bus16_o,
    output logic              cfg_direct_o,
    output logic              cfg_m68k_o,
    output logic              cfg_swap_o
);
    localparam int BYTE_W = DATA_W / 2;

    strap_t           cfg;
    logic             active, is_wr, is_rd;
    logic             swap_eff;
    logic [BYTE_W-1:0] wr_lane;
    logic [BYTE_W-1:0] rd_lane;
    logic [IDX_W-1:0] idx;

    hpd_strap_latch u_straps (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cfg_o(cfg)
    );

    hpd_strobe_decode u_strobe (
        .m68k_i(cfg.m68k), .rd_n_i(io_rd_n), .wr_n_i(io_wr_n),
        .active_o(active), .write_o(is_wr), .read_o(is_rd)
    );

    hpd_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .haddr_i(haddr_i),
        .io_cs_n(io_cs_n), .mem_cs_n(mem_cs_n), .active_i(active),
        .io_hit_o(io_hit_o), .mem_hit_o(mem_hit_o)
    );

    // Split an I/O hit into index port or register/data port.
    always_comb begin
        idx_hit_o = io_hit_o && !cfg.direct && !haddr_i[0];
        reg_hit_o = io_hit_o && (cfg.direct || haddr_i[0]);
        reg_sel_o = cfg.direct ? haddr_i[IDX_W:1] : idx;
    end

    // Byte lane selection for index write data.
    always_comb begin
        swap_eff = cfg.swap && cfg.bus16;
        wr_lane  = swap_eff ? hdata_i[DATA_W-1:BYTE_W] : hdata_i[BYTE_W-1:0];
    end

    hpd_index_reg u_index (
        .clk(clk), .rst_n(rst_n), .we_i(idx_hit_o && is_wr),
        .wdata_i(wr_lane[IDX_W-1:0]), .idx_o(idx)
    );

    // Read-back steering of the index onto the data bus.
    always_comb begin
        rd_lane   = {{(BYTE_W-IDX_W){1'b0}}, idx};
        rd_data_o = '0;
        if (idx_hit_o && is_rd) begin
            if (swap_eff) rd_data_o[DATA_W-1:BYTE_W] = rd_lane;
            else          rd_data_o[BYTE_W-1:0]      = rd_lane;
        end
    end

    assign cfg_bus16_o  = cfg.bus16;
    assign cfg_direct_o = cfg.direct;
    assign cfg_m68k_o   = cfg.m68k;
    assign cfg_swap_o   = cfg.swap;

    // R4
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_hit_o, reg_hit_o}));
    // R3
    direct_no_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_direct_o |-> !idx_hit_o);
    // R2
    narrow_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bus16_o |-> (rd_data_o[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/tb_host_port_decoder.sv
module tb_host_port_decoder;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] strap_i = 0;
    logic [19:0] haddr_i = 0;
    logic [15:0] hdata_i = 0;
    logic        io_cs_n = 1, io_rd_n = 1, io_wr_n = 1, mem_cs_n = 1;
    logic        io_hit_o, mem_hit_o, idx_hit_o, reg_hit_o;
    logic [3:0]  reg_sel_o;
    logic [15:0] rd_data_o;
    logic        cfg_bus16_o, cfg_direct_o, cfg_m68k_o, cfg_swap_o;

    int nchk = 0, nerr = 0;
    bit chk_en = 0, done = 0;
    logic [15:0] m_s = 0;
    logic [3:0]  m_idx = 0;

    host_port_decoder dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit f_active();
        return m_s[2] ? !io_rd_n : (!io_rd_n || !io_wr_n);
    endfunction
    function automatic bit f_wr();
        return m_s[2] ? (!io_rd_n && !io_wr_n) : !io_wr_n;
    endfunction
    function automatic bit f_iohit();
        bit m;
        m = m_s[1] ? (haddr_i[9:5] == m_s[12:8]) : (haddr_i[9:1] == m_s[12:4]);
        return !io_cs_n && f_active() && m;
    endfunction
    function automatic bit f_idxhit();
        return f_iohit() && !m_s[1] && !haddr_i[0];
    endfunction

    // Reference model state update.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s = strap_i;
            m_idx = 0;
        end else if (f_idxhit() && f_wr()) begin
            m_idx = (m_s[3] && m_s[0]) ? hdata_i[11:8] : hdata_i[3:0];
        end
    end

    // Compare every cycle away from the clock edge.
    always @(negedge clk) begin
        if (chk_en) begin
            bit sw, io, ih, rh;
            int rd;
            sw = m_s[3] && m_s[0];
            io = f_iohit();
            ih = f_idxhit();
            rh = io && (m_s[1] || haddr_i[0]);
            rd = (ih && f_active() && !f_wr()) ? (sw ? (int'(m_idx) << 8) : int'(m_idx)) : 0;
            chk("R1", "cfg", {cfg_swap_o, cfg_m68k_o, cfg_direct_o, cfg_bus16_o}, m_s[3:0]);
            chk(m_s[2] ? "R5" : "R7", "io_hit", io_hit_o, io);
            chk("R8", "mem_hit", mem_hit_o, !mem_cs_n && haddr_i[19:17] == m_s[15:13]);
            chk(m_s[1] ? "R3" : "R4", "idx_hit", idx_hit_o, ih);
            chk(m_s[1] ? "R3" : "R4", "reg_hit", reg_hit_o, rh);
            chk(m_s[1] ? "R3" : "R4", "reg_sel", reg_sel_o, m_s[1] ? haddr_i[4:1] : m_idx);
            chk(sw ? "R6" : (m_s[0] ? "R9" : "R2"), "rd_data", rd_data_o, rd);
        end
    end

    task automatic bus_op(input logic [19:0] a, input bit wr, input bit iocs, input bit memcs,
                          input logic [15:0] d);
        @(posedge clk); #1;
        haddr_i = a; hdata_i = d; io_cs_n = !iocs; mem_cs_n = !memcs;
        if (m_s[2]) begin io_rd_n = 0; io_wr_n = !wr; end
        else begin io_rd_n = wr; io_wr_n = !wr; end
        @(posedge clk); #1;
        @(posedge clk); #1;
        io_cs_n = 1; mem_cs_n = 1; io_rd_n = 1; io_wr_n = 1;
    endtask

    task automatic run_cfg(input logic [2:0] mb, input logic [8:0] ib, input logic [3:0] mode);
        logic [15:0] s;
        logic [19:0] base;
        s = {mb, ib, mode};
        @(posedge clk); #1;
        rst_n = 0; strap_i = s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk_en = 1;
        @(posedge clk); #1;
        strap_i = ~s;              // R1: must be ignored
        base = {11'h0, ib, 1'b0};
        bus_op(base, 0, 1, 0, 0);  // R9: index reads zero after reset
        for (int i = 0; i < 48; i++) begin
            logic [19:0] a;
            logic [15:0] d;
            d = 16'(i * 16'h1357);
            case (i % 8)
                0: a = base;
                1: a = base | 20'h1;
                2: a = base ^ 20'(((i / 8) % 16) << 1);
                3: a = base ^ 20'(1 << (1 + (i % 9)));
                4: a = base | 20'(i << 10);
                5: a = {mb, 17'(i * 977)};
                6: a = {mb ^ 3'(1 << (i % 3)), 17'h0};
                default: a = base | 20'h1;
            endcase
            bus_op(a, (i % 3) == 0, (i % 8) != 7 && (i % 8) != 5, (i % 8) >= 5, d);
            if ((i % 8) == 0) bus_op(base, 0, 1, 0, 0);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        run_cfg(3'd5, 9'h180, 4'b0000);
        run_cfg(3'd5, 9'h180, 4'b0011);
        run_cfg(3'd2, 9'h0A5, 4'b1001);
        run_cfg(3'd7, 9'h1FF, 4'b1111);
        run_cfg(3'd0, 9'h000, 4'b1100);
        run_cfg(3'd3, 9'h155, 4'b0101);
        @(posedge clk); #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule